// File: doc/BRIEF.md
# MSI Event Ring Writer

The block takes inbound message-signalled interrupt writes, each carrying a 16-bit interrupt number. It turns every accepted message into a 16-byte record and issues one memory-write request per record. Each record goes to a circular buffer in system memory at the buffer base plus the current write offset. The host drains the buffer at its own pace. It acknowledges consumed records by moving the read offset. The block keeps an interrupt line high while unread records remain.

Software sets the block up through a small word-addressed register bus. The registers hold a control word, a 64-bit buffer base split into two halves, the read offset, the write offset and a count of dropped messages. The control word sets the ring size as a power-of-two exponent between 2^15 and 2^18 bytes. It also selects what happens when the ring fills: new messages are either dropped and counted, or the oldest record is overwritten.

Top module: `msi_ring_writer`

## Requirements
- R1: Register word addresses: 0 control, 3 base high word, 4 base low word, 5 read offset, 6 write offset (read-only, writes ignored), 7 dropped-message count (read-only). Addresses 1 and 2 read as zero. Reads are combinational from `reg_addr`.
- R2: Control fields: bit 0 enable, bit 1 full-interrupt enable, bit 3 interrupt enable, bit 4 stop-on-full, bits 9:8 size code k giving a ring of 2^(15+k) bytes. All other bits read as zero.
- R3: Each record is one request. The address is base plus write offset. `mem_data` is the 16-byte record in little-endian byte order: bits 15:0 carry the interrupt number and bits 127:16 are zero.
- R4: After each completed request (`mem_valid` and `mem_ready` both high), the write offset advances by 16. It wraps from ring size minus 16 to zero.
- R5: A write to the read offset stores the value with bits 3:0 cleared and masked to the ring size. Both offsets always read back 16-byte aligned and inside the ring.
- R6: `irq` is high when enable and interrupt enable are set and the read offset differs from the write offset.
- R7: The ring is full when (write offset + 16) modulo ring size equals the read offset. With enable and full-interrupt enable set, `irq` is high while the ring is full, even when interrupt enable is clear.
- R8: With stop-on-full set, a message accepted while the ring is full makes no request and leaves both offsets unchanged. It increments the drop count, which saturates.
- R9: With stop-on-full clear, a message accepted while full is written. The write offset advances and the read offset also advances by 16, so the oldest record is discarded.
- R10: While enable is clear, messages are accepted and discarded: no request is made and the write offset holds.
- R11: A request holds `mem_valid`, `mem_addr` and `mem_data` stable until `mem_ready`. `msg_ready` is low while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| msg_valid | input | 1 | Inbound message present |
| msg_num | input | 16 | Interrupt number of the message |
| msg_ready | output | 1 | Block accepts the message this cycle |
| mem_valid | output | 1 | Record write request pending |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record contents, little-endian |
| mem_ready | input | 1 | Memory accepts the request |
| irq | output | 1 | Interrupt to the host |

## Verification
The record path is exercised in several ways. One message gets an immediate `mem_ready` and another is stalled for several cycles, which separates correct formatting from a request that changes or drops out under back-pressure. Messages sent with the block disabled, or into a full ring with stop-on-full set, must produce no request. Unread records and a full ring each raise the interrupt on their own, which separates the two interrupt sources. A long run of messages carries the write offset across the wrap point and then into an overwrite. That run shows whether the ring size is applied and whether the read offset is pushed forward.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int MIN_SHIFT = 15;
  localparam int MAX_SHIFT = 18;
  localparam int OFF_W     = MAX_SHIFT;
  localparam int REC_BYTES = 16;
  localparam int REC_W     = REC_BYTES * 8;
  localparam int SIZE_W    = 2;

  typedef enum logic [2:0] {
    RA_CTRL    = 3'd0,
    RA_BASE_HI = 3'd3,
    RA_BASE_LO = 3'd4,
    RA_RD_OFF  = 3'd5,
    RA_WR_OFF  = 3'd6,
    RA_DROPS   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              stop;
    logic              irq_en;
    logic              full_en;
    logic              en;
  } ctrl_t;

  function automatic logic [OFF_W-1:0] ring_mask(input logic [SIZE_W-1:0] sz);
    logic [OFF_W-1:0] m;
    m = {OFF_W{1'b1}} >> (2'd3 - sz);
    return m & {{(OFF_W-4){1'b1}}, 4'h0};
  endfunction
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [2:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output ctrl_t                    ctrl_o,
  output logic [63:0]              base_o,
  output logic                     rd_we_o,
  output logic [OFF_W-1:0]         rd_wdata_o,
  input  logic [OFF_W-1:0]         rd_off_i,
  input  logic [OFF_W-1:0]         wr_off_i,
  input  logic [DROP_W-1:0]        drops_i
);
  ctrl_t       ctrl_q, ctrl_d;
  logic [31:0] hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    ctrl_d = ctrl_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (reg_we) begin
      case (reg_addr)
        RA_CTRL: begin
          ctrl_d.en      = reg_wdata[0];
          ctrl_d.full_en = reg_wdata[1];
          ctrl_d.irq_en  = reg_wdata[3];
          ctrl_d.stop    = reg_wdata[4];
          ctrl_d.size    = reg_wdata[9:8];
        end
        RA_BASE_HI: hi_d = reg_wdata;
        RA_BASE_LO: lo_d = reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign rd_we_o    = reg_we && (reg_addr == RA_RD_OFF);
  assign rd_wdata_o = reg_wdata[OFF_W-1:0];
  assign ctrl_o     = ctrl_q;
  assign base_o     = {hi_q, lo_q};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:    reg_rdata = {22'b0, ctrl_q.size, 3'b0, ctrl_q.stop,
                               ctrl_q.irq_en, 1'b0, ctrl_q.full_en, ctrl_q.en};
      RA_BASE_HI: reg_rdata = hi_q;
      RA_BASE_LO: reg_rdata = lo_q;
      RA_RD_OFF:  reg_rdata[OFF_W-1:0] = rd_off_i;
      RA_WR_OFF:  reg_rdata[OFF_W-1:0] = wr_off_i;
      RA_DROPS:   reg_rdata[DROP_W-1:0] = drops_i;
      default:    reg_rdata = '0;
    endcase
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == RA_CTRL) |=> $stable(ctrl_q)); // R2
endmodule

// File: rtl/msi_ring_ptrs.sv
module msi_ring_ptrs
  import msi_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl_i,
  input  logic             adv_i,
  input  logic             sw_we_i,
  input  logic [OFF_W-1:0] sw_data_i,
  output logic [OFF_W-1:0] rd_off_o,
  output logic [OFF_W-1:0] wr_off_o,
  output logic             full_o,
  output logic             irq_o
);
  logic [OFF_W-1:0] mask, wr_q, wr_d, rd_q, rd_d, wr_m, rd_m, wr_inc, rd_inc;

  assign mask   = ring_mask(ctrl_i.size);
  assign wr_m   = wr_q & mask;
  assign rd_m   = rd_q & mask;
  assign wr_inc = (wr_m + OFF_W'(REC_BYTES)) & mask;
  assign rd_inc = (rd_m + OFF_W'(REC_BYTES)) & mask;
  assign full_o = (wr_inc == rd_m);

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (adv_i) wr_d = wr_inc;
    if (sw_we_i)
      rd_d = sw_data_i & mask;
    else if (adv_i && full_o && !ctrl_i.stop)
      rd_d = rd_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  assign rd_off_o = rd_m;
  assign wr_off_o = wr_m;
  assign irq_o    = ctrl_i.en && ((ctrl_i.irq_en && (rd_m != wr_m)) ||
                                  (ctrl_i.full_en && full_o));

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(wr_q)); // R10
  AST_OVERWRITE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && full_o && !ctrl_i.stop && !sw_we_i) |=> !$stable(rd_q)); // R9
  AST_NO_EMPTY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !sw_we_i) |=> ($stable(ctrl_i.size) -> (wr_off_o != rd_off_o))); // R9
endmodule

// File: rtl/msi_ring_fmt.sv
module msi_ring_fmt
  import msi_ring_pkg::*;
#(
  parameter int NUM_W  = 16,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl_i,
  input  logic [63:0]       base_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic              full_i,
  input  logic              msg_valid,
  input  logic [NUM_W-1:0]  msg_num,
  output logic              msg_ready,
  output logic              mem_valid,
  output logic [63:0]       mem_addr,
  output logic [REC_W-1:0]  mem_data,
  input  logic              mem_ready,
  output logic              adv_o,
  output logic [DROP_W-1:0] drops_o
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;

  state_e             st_q, st_d;
  logic [63:0]        addr_q, addr_d;
  logic [NUM_W-1:0]   num_q, num_d;
  logic [DROP_W-1:0]  drops_q, drops_d;
  logic               take, drop;

  assign msg_ready = (st_q == ST_IDLE);
  assign take      = msg_valid && msg_ready && ctrl_i.en;
  assign drop      = take && full_i && ctrl_i.stop;
  assign adv_o     = (st_q == ST_BUSY) && mem_ready;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    num_d   = num_q;
    drops_d = drops_q;
    case (st_q)
      ST_IDLE: begin
        if (drop) begin
          if (drops_q != {DROP_W{1'b1}}) drops_d = drops_q + 1'b1;
        end else if (take) begin
          addr_d = base_i + 64'(wr_off_i);
          num_d  = msg_num;
          st_d   = ST_BUSY;
        end
      end
      ST_BUSY: if (mem_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      num_q   <= '0;
      drops_q <= '0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      num_q   <= num_d;
      drops_q <= drops_d;
    end
  end

  assign mem_valid = (st_q == ST_BUSY);
  assign mem_addr  = addr_q;
  assign mem_data  = {{(REC_W-NUM_W){1'b0}}, num_q};
  assign drops_o   = drops_q;

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R11
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !msg_ready); // R11
  AST_DROP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !mem_valid); // R8
  AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && !ctrl_i.en) |=> !mem_valid); // R10
endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
  import msi_ring_pkg::*;
#(
  parameter int NUM_W  = 16,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              msg_valid,
  input  logic [NUM_W-1:0]  msg_num,
  output logic              msg_ready,
  output logic              mem_valid,
  output logic [63:0]       mem_addr,
  output logic [REC_W-1:0]  mem_data,
  input  logic              mem_ready,
  output logic              irq
);
  ctrl_t              ctrl;
  logic [63:0]        base;
  logic               rd_we, adv, full;
  logic [OFF_W-1:0]   rd_wdata, rd_off, wr_off;
  logic [DROP_W-1:0]  drops;

  msi_ring_regs #(.DROP_W(DROP_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .ctrl_o(ctrl), .base_o(base), .rd_we_o(rd_we), .rd_wdata_o(rd_wdata),
    .rd_off_i(rd_off), .wr_off_i(wr_off), .drops_i(drops)
  );

  msi_ring_ptrs u_ptrs (
    .clk, .rst_n, .ctrl_i(ctrl), .adv_i(adv), .sw_we_i(rd_we),
    .sw_data_i(rd_wdata), .rd_off_o(rd_off), .wr_off_o(wr_off),
    .full_o(full), .irq_o(irq)
  );

  msi_ring_fmt #(.NUM_W(NUM_W), .DROP_W(DROP_W)) u_fmt (
    .clk, .rst_n, .ctrl_i(ctrl), .base_i(base), .wr_off_i(wr_off),
    .full_i(full), .msg_valid, .msg_num, .msg_ready, .mem_valid,
    .mem_addr, .mem_data, .mem_ready, .adv_o(adv), .drops_o(drops)
  );

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> !irq); // R6
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !(reg_we && reg_addr == RA_CTRL)) |=>
      (wr_off == (($past(wr_off) + OFF_W'(REC_BYTES)) & ring_mask(ctrl.size)))); // R4
  AST_OFF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_off[3:0] == 4'h0) && (rd_off[3:0] == 4'h0)); // R5
endmodule

// File: tb/msi_ring_writer_test.sv
module msi_ring_writer_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msg_valid = 1'b0;
  logic [15:0]  msg_num = '0;
  logic         msg_ready;
  logic         mem_valid;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         mem_ready = 1'b1;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] base = 64'h0000_0001_2345_0000;

  always #5 clk = ~clk;

  msi_ring_writer uut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .msg_valid, .msg_num, .msg_ready, .mem_valid, .mem_addr, .mem_data,
    .mem_ready, .irq
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd_reg(a, v);
    chk(v == e, req, $sformatf("reg %0d", a), 128'(v), 128'(e));
  endtask

  // send one message; if expect_wr, check the request at exp_off, stalled for stall cycles
  task automatic send(input logic [15:0] num, input bit expect_wr,
                      input logic [31:0] exp_off, input int stall, input string req);
    @(negedge clk); msg_valid = 1'b1; msg_num = num; mem_ready = (stall == 0);
    while (!msg_ready) @(negedge clk);
    @(negedge clk); msg_valid = 1'b0;
    if (expect_wr) begin
      chk(mem_valid === 1'b1, req, "mem_valid", 128'(mem_valid), 128'(1));
      chk(mem_addr == base + 64'(exp_off), req, "mem_addr", 128'(mem_addr),
          128'(base + 64'(exp_off)));
      chk(mem_data == 128'(num), req, "mem_data", mem_data, 128'(num));
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk(mem_valid && mem_addr == base + 64'(exp_off) && mem_data == 128'(num) && !msg_ready,
            "R11", "stalled request", 128'(mem_addr), 128'(base + 64'(exp_off)));
      end
      mem_ready = 1'b1;
      @(negedge clk);
      chk(mem_valid === 1'b0, req, "request retired", 128'(mem_valid), 128'(0));
    end else begin
      chk(mem_valid === 1'b0, req, "no request", 128'(mem_valid), 128'(0));
    end
  endtask

  task automatic send_quick(input logic [15:0] num);
    @(negedge clk); msg_valid = 1'b1; msg_num = num; mem_ready = 1'b1;
    while (!msg_ready) @(negedge clk);
    @(negedge clk); msg_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(irq === 1'b0, "R6", "irq after reset", 128'(irq), 128'(0));
    chk(mem_valid === 1'b0, "R11", "mem_valid after reset", 128'(mem_valid), 128'(0));
    chk(msg_ready === 1'b1, "R11", "msg_ready after reset", 128'(msg_ready), 128'(1));
    chk_reg(3'd0, 32'h0, "R1");
    chk_reg(3'd6, 32'h0, "R1");
  endtask

  task automatic t_regs();
    wr_reg(3'd0, 32'hFFFF_FCE4);           // no enable set, size code 0
    chk_reg(3'd0, 32'h0000_0000, "R2");
    wr_reg(3'd0, 32'hFFFF_FFFE);           // all fields but enable
    chk_reg(3'd0, 32'h0000_031A, "R2");
    wr_reg(3'd3, base[63:32]);
    wr_reg(3'd4, base[31:0]);
    chk_reg(3'd3, base[63:32], "R1");
    chk_reg(3'd4, base[31:0], "R1");
    wr_reg(3'd1, 32'hDEAD_BEEF);
    chk_reg(3'd1, 32'h0, "R1");
    chk_reg(3'd2, 32'h0, "R1");
    wr_reg(3'd6, 32'h0000_0100);
    chk_reg(3'd6, 32'h0, "R1");
    wr_reg(3'd5, 32'h0003_FFFF);           // 256 KB ring
    chk_reg(3'd5, 32'h0003_FFF0, "R5");
    wr_reg(3'd5, 32'h0);
    wr_reg(3'd0, 32'h0);
  endtask

  task automatic t_disabled();
    send(16'h1111, 1'b0, 0, 0, "R10");
    chk_reg(3'd6, 32'h0, "R10");
    chk_reg(3'd7, 32'h0, "R10");
  endtask

  task automatic t_basic();
    wr_reg(3'd0, 32'h0000_0009);           // enable + irq enable, 32 KB
    chk(irq === 1'b0, "R6", "irq empty", 128'(irq), 128'(0));
    send(16'hABCD, 1'b1, 32'h0, 0, "R3");
    chk_reg(3'd6, 32'h10, "R4");
    chk(irq === 1'b1, "R6", "irq pending", 128'(irq), 128'(1));
    send(16'hFFFF, 1'b1, 32'h10, 3, "R3");
    chk_reg(3'd6, 32'h20, "R4");
    wr_reg(3'd5, 32'h0000_0020);
    chk(irq === 1'b0, "R6", "irq after ack", 128'(irq), 128'(0));
    wr_reg(3'd5, 32'h0001_2345);           // masked to 32 KB, aligned
    chk_reg(3'd5, 32'h0000_2340, "R5");
    wr_reg(3'd5, 32'h0000_0020);
  endtask

  task automatic t_full_stop();
    wr_reg(3'd0, 32'h0000_0011);           // enable + stop, no interrupt enables
    wr_reg(3'd5, 32'h0000_0030);           // wr=0x20: full
    chk(irq === 1'b0, "R7", "full, no full enable", 128'(irq), 128'(0));
    wr_reg(3'd0, 32'h0000_0013);           // add full-interrupt enable
    chk(irq === 1'b1, "R7", "full interrupt", 128'(irq), 128'(1));
    send(16'h0042, 1'b0, 0, 0, "R8");
    chk_reg(3'd6, 32'h20, "R8");
    chk_reg(3'd5, 32'h30, "R8");
    chk_reg(3'd7, 32'h1, "R8");
    send(16'h0043, 1'b0, 0, 0, "R8");
    chk_reg(3'd7, 32'h2, "R8");
  endtask

  task automatic t_wrap_overwrite();
    logic [31:0] w;
    int n1;
    wr_reg(3'd0, 32'h0000_0001);           // enable only, overwrite mode, 32 KB
    rd_reg(3'd6, w);
    wr_reg(3'd5, w);
    n1 = (32'h8000 - int'(w)) / 16 - 1;
    for (int i = 0; i < n1; i++) send_quick(16'(i));
    chk_reg(3'd6, 32'h7FF0, "R4");
    send(16'h0777, 1'b1, 32'h7FF0, 0, "R4");
    chk_reg(3'd6, 32'h0, "R4");
    for (int i = 0; i < 2047 - n1 - 1; i++) send_quick(16'(i));
    chk_reg(3'd6, w - 32'h10, "R9");
    chk_reg(3'd5, w, "R9");
    send(16'h0BEE, 1'b1, w - 32'h10, 0, "R9");
    chk_reg(3'd6, w, "R9");
    chk_reg(3'd5, w + 32'h10, "R9");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_basic();
    t_full_stop();
    t_wrap_overwrite();
    finish_run();
  end
endmodule